// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block holds 4096 bits of storage that two independent ports, A and B, can read and write. Each port has its own clock, enable, write enable, synchronous output clear, address, write data and read data. The data width of each port is a parameter, chosen from 1, 2, 4, 8 or 16 bits. The address width follows from that width. Both ports see one bit array, so a value written as a 16-bit word on one port can be read bit by bit on a 1-bit port.

A port address selects a run of bits whose position is the address times the port width. Each port has a one-cycle read. On a write, the written data appears on that port's output. Every control pin of every port, the clock included, has a parameter that flips its active level or edge.

Each port has a collision flag. It is raised when the other port writes bits that overlap the bits this port accessed on the same edge. The flag tells the user that the value read, or the bits written by both ports, cannot be trusted. For the flag, the two port clocks are treated as one clock domain.

Top module: `mwdp_ram`

## Requirements
- R1: The storage holds 4096 bits. A port of width W (1, 2, 4, 8 or 16) has 4096/W locations and log2(4096/W) address bits.
- R2: Address N on a port of width W covers array bits N*W through N*W+W-1, and data out bit i is array bit N*W+i. The mapping is the same on both ports whatever their widths, so data written at one width reads back correctly at another.
- R3: A rising edge with enable active, write enable inactive and clear inactive is a read. From that edge, data out holds the addressed bits.
- R4: A rising edge with enable and write enable active and clear inactive is a write. It stores data in at the address, and from that edge data out equals the written data.
- R5: A rising edge with enable and clear both active sets data out to zero. Any write on that edge is suppressed and the memory contents stay unchanged.
- R6: A rising edge with enable inactive neither reads nor writes, whatever the levels of write enable and clear. Data out keeps its value.
- R7: Each port has four parameters, one each for the clock, enable, write enable and clear. A value of 1 makes that control active low, or for the clock makes the falling edge the active edge. A value of 0 keeps the control active high, or the clock rising-edge.
- R8: A port's collision flag is registered with its data out. It is 1 after an edge on which that port had enable active and the other port wrote bits that overlap this port's bit range. After any other edge it is 0.
- R9: When one port writes and the other reads overlapping bits on the same edge, the write is stored. The writing port's data out equals its data in, and its collision flag stays 0.
- R10: At power-up, both data outputs and both collision flags are zero and every memory bit reads as zero.
- R11: When both ports write overlapping bits on the same edge, both flags are raised. Bits that only one port wrote hold that port's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous output clear |
| addr_a | input | log2(4096/WIDTH_A) | Port A address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A read data |
| coll_a | output | 1 | Port A collision flag |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous output clear |
| addr_b | input | log2(4096/WIDTH_B) | Port B address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B read data |
| coll_b | output | 1 | Port B collision flag |

## Verification
The bench runs port A at 16 bits and port B at 1 bit, with B's enable, write enable and clear made active low. This combination catches a wrong bit-offset formula or an inverted polarity parameter: a 16-bit word read back bit by bit would return bits from the wrong word, or a port would act on the wrong pin level.

- **Clear with write:** a write issued on the same edge as a clear must not reach the array. A design that let it through would change the word returned by the next read.
- **Idle port:** a disabled port with its write enable and clear active must leave both its data out and the memory unchanged.
- **Write against read:** when one port writes while the other reads the same bits, only the reading port's flag may rise. The written word must still read back.
- **Write against write:** when both ports write overlapping bits, both flags must rise. The bits only one port wrote must hold that port's data.
- **No false flag:** concurrent writes to disjoint locations must raise no flag. This catches an overlap compare done at the wrong granularity.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;
    // total shared storage in bits
    localparam int MEM_BITS = 4096;
    // bit-index width into the shared array
    localparam int IDX_W = $clog2(MEM_BITS);

    // decoded per-edge operation of one port
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;
endpackage

// File: rtl/mwdp_pin_norm.sv
module mwdp_pin_norm
    import mwdp_pkg::*;
#(
    parameter bit INV_CLK = 1'b0,
    parameter bit INV_EN  = 1'b0,
    parameter bit INV_WE  = 1'b0,
    parameter bit INV_RST = 1'b0
) (
    input  logic clk_pin,
    input  logic en_pin,
    input  logic we_pin,
    input  logic rst_pin,
    output logic clk_o,
    output op_e  op_o
);
    logic en_act;
    logic we_act;
    logic rst_act;

    generate
        if (INV_CLK) begin : g_clk_fall
            assign clk_o = ~clk_pin;
        end else begin : g_clk_rise
            assign clk_o = clk_pin;
        end
    endgenerate

    assign en_act  = en_pin  ^ INV_EN;
    assign we_act  = we_pin  ^ INV_WE;
    assign rst_act = rst_pin ^ INV_RST;

    // clear wins over write; enable gates everything
    always_comb begin
        if (!en_act)      op_o = OP_IDLE;
        else if (rst_act) op_o = OP_CLEAR;
        else if (we_act)  op_o = OP_WRITE;
        else              op_o = OP_READ;
    end
endmodule

// File: rtl/mwdp_overlap.sv
module mwdp_overlap
    import mwdp_pkg::*;
#(
    parameter int WIDTH_A = 16,
    parameter int WIDTH_B = 1,
    localparam int LW_A = $clog2(WIDTH_A),
    localparam int LW_B = $clog2(WIDTH_B),
    localparam int AW_A = IDX_W - LW_A,
    localparam int AW_B = IDX_W - LW_B,
    localparam int LW_MAX = (LW_A > LW_B) ? LW_A : LW_B
) (
    input  logic [AW_A-1:0] addr_a,
    input  logic [AW_B-1:0] addr_b,
    output logic            hit
);
    logic [IDX_W-1:0] start_a;
    logic [IDX_W-1:0] start_b;

    assign start_a = IDX_W'(addr_a) << LW_A;
    assign start_b = IDX_W'(addr_b) << LW_B;

    // widths are powers of two: ranges overlap iff they share the wider block
    assign hit = (start_a >> LW_MAX) == (start_b >> LW_MAX);
endmodule

// File: rtl/mwdp_port.sv
module mwdp_port
    import mwdp_pkg::*;
#(
    parameter int W = 16,
    localparam int LW = $clog2(W),
    localparam int AW = IDX_W - LW
) (
    input  logic                clk,
    input  op_e                 op,
    input  logic [AW-1:0]       addr,
    input  logic [W-1:0]        din,
    input  logic [MEM_BITS-1:0] peer_bank,
    input  logic                peer_wr_hit,
    output logic [MEM_BITS-1:0] own_bank,
    output logic [W-1:0]        dout,
    output logic                coll
);
    typedef struct packed {
        logic [MEM_BITS-1:0] bank;
        logic [W-1:0]        dout;
        logic                coll;
    } state_t;

    state_t st_d;
    state_t st_q = '0;

    logic [IDX_W-1:0] base;

    assign base = IDX_W'(addr) << LW;

    // the stored word is own bank XOR peer bank over the addressed range
    always_comb begin
        st_d      = st_q;
        st_d.coll = (op != OP_IDLE) && peer_wr_hit;
        case (op)
            OP_WRITE: begin
                st_d.bank[base +: W] = din ^ peer_bank[base +: W];
                st_d.dout            = din;
            end
            OP_READ:  st_d.dout = st_q.bank[base +: W] ^ peer_bank[base +: W];
            OP_CLEAR: st_d.dout = '0;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign own_bank = st_q.bank;
    assign dout     = st_q.dout;
    assign coll     = st_q.coll;
endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram
    import mwdp_pkg::*;
#(
    parameter int WIDTH_A   = 16,
    parameter int WIDTH_B   = 1,
    parameter bit INV_CLK_A = 1'b0,
    parameter bit INV_EN_A  = 1'b0,
    parameter bit INV_WE_A  = 1'b0,
    parameter bit INV_RST_A = 1'b0,
    parameter bit INV_CLK_B = 1'b0,
    parameter bit INV_EN_B  = 1'b0,
    parameter bit INV_WE_B  = 1'b0,
    parameter bit INV_RST_B = 1'b0,
    localparam int AW_A = IDX_W - $clog2(WIDTH_A),
    localparam int AW_B = IDX_W - $clog2(WIDTH_B)
) (
    input  logic               clk_a,
    input  logic               en_a,
    input  logic               we_a,
    input  logic               rst_a,
    input  logic [AW_A-1:0]    addr_a,
    input  logic [WIDTH_A-1:0] din_a,
    output logic [WIDTH_A-1:0] dout_a,
    output logic               coll_a,
    input  logic               clk_b,
    input  logic               en_b,
    input  logic               we_b,
    input  logic               rst_b,
    input  logic [AW_B-1:0]    addr_b,
    input  logic [WIDTH_B-1:0] din_b,
    output logic [WIDTH_B-1:0] dout_b,
    output logic               coll_b
);
    logic                clk_a_i;
    logic                clk_b_i;
    op_e                 op_a;
    op_e                 op_b;
    logic                hit;
    logic [MEM_BITS-1:0] bank_a;
    logic [MEM_BITS-1:0] bank_b;

    mwdp_pin_norm #(
        .INV_CLK(INV_CLK_A), .INV_EN(INV_EN_A),
        .INV_WE(INV_WE_A),   .INV_RST(INV_RST_A)
    ) u_norm_a (
        .clk_pin(clk_a), .en_pin(en_a), .we_pin(we_a), .rst_pin(rst_a),
        .clk_o(clk_a_i), .op_o(op_a)
    );

    mwdp_pin_norm #(
        .INV_CLK(INV_CLK_B), .INV_EN(INV_EN_B),
        .INV_WE(INV_WE_B),   .INV_RST(INV_RST_B)
    ) u_norm_b (
        .clk_pin(clk_b), .en_pin(en_b), .we_pin(we_b), .rst_pin(rst_b),
        .clk_o(clk_b_i), .op_o(op_b)
    );

    mwdp_overlap #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_overlap (
        .addr_a(addr_a), .addr_b(addr_b), .hit(hit)
    );

    mwdp_port #(.W(WIDTH_A)) u_port_a (
        .clk(clk_a_i), .op(op_a), .addr(addr_a), .din(din_a),
        .peer_bank(bank_b), .peer_wr_hit(hit && (op_b == OP_WRITE)),
        .own_bank(bank_a), .dout(dout_a), .coll(coll_a)
    );

    mwdp_port #(.W(WIDTH_B)) u_port_b (
        .clk(clk_b_i), .op(op_b), .addr(addr_b), .din(din_b),
        .peer_bank(bank_a), .peer_wr_hit(hit && (op_a == OP_WRITE)),
        .own_bank(bank_b), .dout(dout_b), .coll(coll_b)
    );
endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk
    import mwdp_pkg::*;
#(
    parameter int WIDTH_A = 16,
    parameter int WIDTH_B = 1
) (
    input logic               clk_a,
    input logic               clk_b,
    input op_e                op_a,
    input op_e                op_b,
    input logic [WIDTH_A-1:0] din_a,
    input logic [WIDTH_B-1:0] din_b,
    input logic [WIDTH_A-1:0] dout_a,
    input logic [WIDTH_B-1:0] dout_b,
    input logic               coll_a,
    input logic               coll_b
);
    logic armed_a = 1'b0;
    logic armed_b = 1'b0;

    always_ff @(posedge clk_a) armed_a <= 1'b1;
    always_ff @(posedge clk_b) armed_b <= 1'b1;

    // R4
    a_write_through_chk: assert property (@(posedge clk_a) disable iff (!armed_a)
        (op_a == OP_WRITE) |=> (dout_a == $past(din_a)));
    // R4
    b_write_through_chk: assert property (@(posedge clk_b) disable iff (!armed_b)
        (op_b == OP_WRITE) |=> (dout_b == $past(din_b)));
    // R5
    a_clear_zero_chk: assert property (@(posedge clk_a) disable iff (!armed_a)
        (op_a == OP_CLEAR) |=> (dout_a == '0));
    // R5
    b_clear_zero_chk: assert property (@(posedge clk_b) disable iff (!armed_b)
        (op_b == OP_CLEAR) |=> (dout_b == '0));
    // R6
    a_idle_hold_chk: assert property (@(posedge clk_a) disable iff (!armed_a)
        (op_a == OP_IDLE) |=> $stable(dout_a));
    // R6
    b_idle_hold_chk: assert property (@(posedge clk_b) disable iff (!armed_b)
        (op_b == OP_IDLE) |=> $stable(dout_b));
    // R8
    a_flag_needs_peer_write_chk: assert property (@(posedge clk_a) disable iff (!armed_a)
        (op_b != OP_WRITE || op_a == OP_IDLE) |=> !coll_a);
    // R8
    b_flag_needs_peer_write_chk: assert property (@(posedge clk_b) disable iff (!armed_b)
        (op_a != OP_WRITE || op_b == OP_IDLE) |=> !coll_b);
endmodule

bind mwdp_ram mwdp_ram_chk #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_chk (
    .clk_a(clk_a_i), .clk_b(clk_b_i), .op_a(op_a), .op_b(op_b),
    .din_a(din_a), .din_b(din_b), .dout_a(dout_a), .dout_b(dout_b),
    .coll_a(coll_a), .coll_b(coll_b)
);

// File: tb/mwdp_ram_bench.sv
module mwdp_ram_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        en_a = 1'b0, we_a = 1'b0, rst_a = 1'b0;
    logic [7:0]  addr_a = '0;
    logic [15:0] din_a = '0;
    logic [15:0] dout_a;
    logic        coll_a;
    // port B pins are active low in this bench
    logic        en_b = 1'b1, we_b = 1'b1, rst_b = 1'b1;
    logic [11:0] addr_b = '0;
    logic [0:0]  din_b = '0;
    logic [0:0]  dout_b;
    logic        coll_b;

    logic [4095:0] ref_mem = '0;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwdp_ram #(
        .WIDTH_A(16), .WIDTH_B(1),
        .INV_EN_B(1'b1), .INV_WE_B(1'b1), .INV_RST_B(1'b1)
    ) u_mwdp_ram (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a(rst_a),
        .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a), .coll_a(coll_a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b(rst_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b), .coll_b(coll_b)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_a(input logic en, input logic we, input logic rst,
                         input logic [7:0] addr, input logic [15:0] din);
        en_a = en; we_a = we; rst_a = rst; addr_a = addr; din_a = din;
    endtask

    task automatic set_b(input logic en, input logic we, input logic rst,
                         input logic [11:0] addr, input logic din);
        en_b = ~en; we_b = ~we; rst_b = ~rst; addr_b = addr; din_b = din;
    endtask

    // one edge, then sample a quarter period later
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle_both();
        set_a(0, 0, 0, 8'd0, 16'h0);
        set_b(0, 0, 0, 12'd0, 1'b0);
    endtask

    task automatic t_power_up();
        chk("R10 dout_a at power-up", dout_a, 16'h0);
        chk("R10 dout_b at power-up", {15'b0, dout_b}, 16'h0);
        set_a(1, 0, 0, 8'd5, 16'h0);
        set_b(1, 0, 0, 12'd77, 1'b0);
        step();
        chk("R10 read of unwritten word", dout_a, 16'h0);
        chk("R10 read of unwritten bit", {15'b0, dout_b}, 16'h0);
        chk("R8 no flags at idle start", {14'b0, coll_a, coll_b}, 16'h0);
        idle_both();
    endtask

    task automatic t_write_read_a();
        set_a(1, 1, 0, 8'd3, 16'hA5C3);
        step();
        ref_mem[3*16 +: 16] = 16'hA5C3;
        chk("R4 write-through on A", dout_a, 16'hA5C3);
        set_a(1, 0, 0, 8'd0, 16'h0);
        step();
        chk("R3 read of other word on A", dout_a, 16'h0);
        set_a(1, 0, 0, 8'd3, 16'h0);
        step();
        chk("R3 read back on A", dout_a, 16'hA5C3);
        idle_both();
    endtask

    task automatic t_cross_width();
        logic [15:0] word;
        for (int j = 0; j < 16; j++) begin
            set_b(1, 0, 0, 12'(48 + j), 1'b0);
            step();
            chk("R2 bit read of 16-bit word", {15'b0, dout_b}, {15'b0, ref_mem[48 + j]});
        end
        word = 16'h6E19;
        for (int j = 0; j < 16; j++) begin
            set_b(1, 1, 0, 12'(160 + j), word[j]);
            step();
            ref_mem[160 + j] = word[j];
            chk("R4 write-through on B", {15'b0, dout_b}, {15'b0, word[j]});
        end
        set_b(0, 0, 0, 12'd0, 1'b0);
        set_a(1, 0, 0, 8'd10, 16'h0);
        step();
        chk("R2 word read of bit writes", dout_a, ref_mem[160 +: 16]);
        idle_both();
    endtask

    task automatic t_clear();
        set_a(1, 1, 0, 8'd4, 16'hBEEF);
        step();
        set_a(1, 1, 1, 8'd4, 16'h1111);
        step();
        chk("R5 clear zeroes dout_a", dout_a, 16'h0);
        set_a(1, 0, 0, 8'd4, 16'h0);
        step();
        chk("R5 write with clear suppressed", dout_a, 16'hBEEF);
        set_a(0, 0, 0, 8'd0, 16'h0);
        set_b(1, 0, 0, 12'd48, 1'b0);
        step();
        chk("R7 active-low B read", {15'b0, dout_b}, 16'h1);
        set_b(1, 1, 1, 12'd48, 1'b0);
        step();
        chk("R5 clear zeroes dout_b", {15'b0, dout_b}, 16'h0);
        set_b(1, 0, 0, 12'd48, 1'b0);
        step();
        chk("R5 B write with clear suppressed", {15'b0, dout_b}, 16'h1);
        idle_both();
    endtask

    task automatic t_idle();
        set_a(1, 0, 0, 8'd3, 16'h0);
        set_b(1, 0, 0, 12'd49, 1'b0);
        step();
        set_a(0, 1, 1, 8'd3, 16'h0000);
        set_b(0, 1, 1, 12'd49, 1'b0);
        step();
        chk("R6 idle A holds dout", dout_a, 16'hA5C3);
        chk("R6 R7 idle B holds dout", {15'b0, dout_b}, {15'b0, ref_mem[49]});
        set_a(1, 0, 0, 8'd3, 16'h0);
        set_b(1, 0, 0, 12'd49, 1'b0);
        step();
        chk("R6 idle A left memory", dout_a, 16'hA5C3);
        chk("R6 idle B left memory", {15'b0, dout_b}, {15'b0, ref_mem[49]});
        idle_both();
    endtask

    task automatic t_write_vs_read();
        set_a(1, 1, 0, 8'd7, 16'h1234);
        set_b(1, 0, 0, 12'd114, 1'b0);
        step();
        ref_mem[7*16 +: 16] = 16'h1234;
        chk("R9 writer dout correct", dout_a, 16'h1234);
        chk("R9 writer flag low", {15'b0, coll_a}, 16'h0);
        chk("R8 reader flag high", {15'b0, coll_b}, 16'h1);
        set_a(1, 0, 0, 8'd7, 16'h0);
        set_b(0, 0, 0, 12'd0, 1'b0);
        step();
        chk("R9 write stored", dout_a, 16'h1234);
        chk("R8 flags drop", {14'b0, coll_a, coll_b}, 16'h0);
        idle_both();
    endtask

    task automatic t_write_vs_write();
        set_a(1, 1, 0, 8'd9, 16'h0F0F);
        set_b(1, 1, 0, 12'd148, 1'b1);
        step();
        chk("R11 both flags", {14'b0, coll_a, coll_b}, 16'h3);
        set_a(1, 0, 0, 8'd9, 16'h0);
        set_b(0, 0, 0, 12'd0, 1'b0);
        step();
        chk("R11 unshared bits keep A data", dout_a & 16'hFFEF, 16'h0F0F & 16'hFFEF);
        ref_mem[9*16 +: 16] = dout_a;
        idle_both();
    endtask

    task automatic t_disjoint();
        set_a(1, 1, 0, 8'd12, 16'hC0DE);
        set_b(1, 1, 0, 12'd0, 1'b1);
        step();
        ref_mem[12*16 +: 16] = 16'hC0DE;
        ref_mem[0] = 1'b1;
        chk("R8 disjoint writes raise no flag", {14'b0, coll_a, coll_b}, 16'h0);
        set_a(1, 0, 0, 8'd12, 16'h0);
        set_b(1, 0, 0, 12'd0, 1'b0);
        step();
        chk("R1 word 12 kept", dout_a, 16'hC0DE);
        chk("R1 bit 0 kept", {15'b0, dout_b}, 16'h1);
        set_a(1, 0, 0, 8'd255, 16'h0);
        set_b(1, 0, 0, 12'd4095, 1'b0);
        step();
        chk("R1 top word reads zero", dout_a, 16'h0);
        chk("R1 top bit reads zero", {15'b0, dout_b}, 16'h0);
        idle_both();
    endtask

    initial begin
        #(CLK_PERIOD/4);
        t_power_up();
        t_write_read_a();
        t_cross_width();
        t_clear();
        t_idle();
        t_write_vs_read();
        t_write_vs_write();
        t_disjoint();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule